// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block generates the pin timing of the external memory bus of an 8-bit controller core. It runs on the oscillator clock. A machine cycle is twelve clocks, split into two six-clock slots. Every slot starts with a two-clock address-latch strobe (`ale`). The low address byte leaves on port 0 during that strobe, and the pins then turn around to carry data. Port 2 carries either the high address byte or the contents of its own port latch.

At each slot boundary the sequencer decides what the next slot does. It runs an external code fetch when the core asks for one and the effective external-access level is low; otherwise the slot is idle. At a machine-cycle boundary a pending data-memory request takes priority and claims the whole twelve clocks. A data cycle keeps only its first address strobe and drops both code-read strobes in favour of a single read or write strobe. Fetched and read bytes come back to the core as one-clock valid pulses. When the lock input is set, the external-access level is frozen at reset.

States (per slot): `SL_IDLE` (strobe only, no bus cycle), `SL_CODE` (external fetch), `SL_DRD` (data read, spans two slots), `SL_DWR` (data write, spans two slots). Transitions are taken on the last clock of a slot. From any state, a data request at the end of a machine cycle goes to `SL_DRD` or `SL_DWR`. `SL_DRD`/`SL_DWR` stay put at the mid-cycle boundary. Otherwise a fetch request with external access low goes to `SL_CODE`, and anything else goes to `SL_IDLE`.

Top module: `xbus_seq`

## Requirements
- R1: Outside data cycles, `ale` is high on clocks 0 and 1 of every six-clock slot and low on clocks 2 to 5, whether or not any fetch is external.
- R2: In a fetch slot, `psen_n` is low on slot clocks 2 to 5 and high on 0 and 1. `p0_oe` is high with `p0_out` equal to the fetch address bits 7:0 on clocks 0 and 1 only.
- R3: In the last clock of a fetch slot (`psen_n` still low), `p0_in` is captured. It appears on `code_data` with `code_valid` high for exactly the next clock.
- R4: A data request seen on the last clock of a machine cycle takes the next twelve clocks, and a fetch request at that point waits. In that cycle `ale` is high only on clocks 0 and 1, the second address strobe is removed, and `psen_n` stays high.
- R5: In a data cycle, exactly one of `rd_n` (read, `dat_we`=0) or `wr_n` (write, `dat_we`=1) is low, on machine-cycle clocks 2 to 9.
- R6: In a write cycle, `p0_oe` is high for all twelve clocks. `p0_out` is the data address bits 7:0 on clocks 0 and 1 and the write byte on clocks 2 to 11, held for the whole `wr_n` low time.
- R7: In a read cycle, port 0 floats (`p0_oe` low) on clocks 2 to 11. `p0_in` is captured on clock 9, the last `rd_n` low clock, and returned on `rd_data` with `rd_valid` high for the next clock.
- R8: `p2_out` carries address bits 15:8 with `p2_strong`=1 in fetch slots and in data cycles with `dat_wide`=1. In data cycles with `dat_wide`=0 and in idle slots it carries `p2_latch` with `p2_strong`=0.
- R9: With effective external access high, no fetch slot occurs: `psen_n` stays high even while `fetch_req` is held.
- R10: With `lock1`=1, the level of `ea_pin` on the last reset clock decides external access until the next reset, and later pin changes are ignored. With `lock1`=0, the live pin level is used at each slot decision.
- R11: During reset the outputs are `ale`=1, `psen_n`=1, `rd_n`=1, `wr_n`=1, `p0_oe`=0, `code_valid`=0 and `rd_valid`=0, and the first clock after reset is clock 0 of an idle slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_req | input | 1 | Core wants a code byte in the next slot |
| fetch_addr | input | 16 | Code address |
| dat_req | input | 1 | Core wants a data-memory access in the next machine cycle |
| dat_we | input | 1 | 1 = write, 0 = read |
| dat_wide | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| dat_addr | input | 16 | Data address |
| dat_wdata | input | 8 | Write byte |
| p2_latch | input | 8 | Port 2 latch contents |
| ea_pin | input | 1 | External-access pin, low = fetch externally |
| lock1 | input | 1 | Freeze the external-access level at reset |
| p0_in | input | 8 | Port 0 pin levels |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Port 0 drive value |
| p0_oe | output | 1 | Port 0 drive enable |
| p2_out | output | 8 | Port 2 drive value |
| p2_strong | output | 1 | Port 2 strong pull-up enable while carrying address |
| code_data | output | 8 | Fetched byte |
| code_valid | output | 1 | One-clock pulse with `code_data` |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | One-clock pulse with `rd_data` |

## Verification
Every pin output is decoded directly from registered slot state. It is therefore due in the same clock where the slot decision takes effect: one clock after the slot-end clock on which the requests and the external-access level were seen. The valid pulses come one clock after their capture clock: slot clock 5 for fetches, machine-cycle clock 9 for reads. The bench drives inputs just after each rising edge. Its behavioural model updates on the rising edge from the same settled inputs the design sees, and all outputs are compared at the falling edge, so every expected value lines up with the cycle the design produces it in.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_CODE = 2'd1,
        SL_DRD  = 2'd2,
        SL_DWR  = 2'd3
    } slot_e;
endpackage

// File: rtl/xbus_frame_ctr.sv
module xbus_frame_ctr #(
    parameter int SLOT_CLKS = 6,
    parameter int PW        = 4
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] pos,
    output logic [PW-1:0] slot_pos,
    output logic          slot_last,
    output logic          cyc_last
);
    localparam int CYC_CLKS = 2 * SLOT_CLKS;
    localparam logic [PW-1:0] SLOT_END = PW'(SLOT_CLKS - 1);
    localparam logic [PW-1:0] CYC_END  = PW'(CYC_CLKS - 1);
    localparam logic [PW-1:0] SLOT_LEN = PW'(SLOT_CLKS);

    always_ff @(posedge clk) begin
        if (rst) pos <= '0;
        else if (cyc_last) pos <= '0;
        else pos <= pos + 1'b1;
    end

    always_comb begin
        cyc_last  = (pos == CYC_END);
        slot_last = (pos == SLOT_END) || cyc_last;
        slot_pos  = (pos < SLOT_LEN) ? pos : pos - SLOT_LEN;
    end
endmodule

// File: rtl/xbus_ea_sel.sv
module xbus_ea_sel (
    input  logic clk,
    input  logic rst,
    input  logic ea_pin,
    input  logic lock1,
    output logic ea_eff
);
    logic ea_hold;

    always_ff @(posedge clk) begin
        if (rst) ea_hold <= ea_pin;
    end

    assign ea_eff = lock1 ? ea_hold : ea_pin;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int SLOT_CLKS   = 6,
    parameter int ALE_CLKS    = 2,
    parameter int STROBE_CLKS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch_req,
    input  logic [AW-1:0] fetch_addr,
    input  logic          dat_req,
    input  logic          dat_we,
    input  logic          dat_wide,
    input  logic [AW-1:0] dat_addr,
    input  logic [DW-1:0] dat_wdata,
    input  logic [DW-1:0] p2_latch,
    input  logic          ea_pin,
    input  logic          lock1,
    input  logic [DW-1:0] p0_in,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] p0_out,
    output logic          p0_oe,
    output logic [DW-1:0] p2_out,
    output logic          p2_strong,
    output logic [DW-1:0] code_data,
    output logic          code_valid,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    localparam int PW = $clog2(2 * SLOT_CLKS);
    localparam logic [PW-1:0] ADDR_END = PW'(ALE_CLKS);
    localparam logic [PW-1:0] STB_LAST = PW'(ALE_CLKS + STROBE_CLKS - 1);

    logic [PW-1:0] pos, slot_pos;
    logic          slot_last, cyc_last, ea_eff;
    slot_e         cur, nxt, pick;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          wide_q;
    logic          in_strobe;

    xbus_frame_ctr #(.SLOT_CLKS(SLOT_CLKS), .PW(PW)) u_frame (
        .clk(clk), .rst(rst), .pos(pos), .slot_pos(slot_pos),
        .slot_last(slot_last), .cyc_last(cyc_last)
    );

    xbus_ea_sel u_ea (
        .clk(clk), .rst(rst), .ea_pin(ea_pin), .lock1(lock1), .ea_eff(ea_eff)
    );

    // slot decision: data at cycle start beats fetch
    always_comb begin
        if (cyc_last && dat_req) pick = dat_we ? SL_DWR : SL_DRD;
        else if (fetch_req && !ea_eff) pick = SL_CODE;
        else pick = SL_IDLE;
        unique case (cur)
            SL_DRD, SL_DWR: nxt = cyc_last ? pick : cur;
            SL_IDLE, SL_CODE: nxt = pick;
            default: nxt = SL_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= SL_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            wide_q  <= 1'b0;
        end else if (slot_last) begin
            cur <= nxt;
            if (nxt == SL_CODE) begin
                addr_q <= fetch_addr;
                wide_q <= 1'b1;
            end else if ((nxt == SL_DRD || nxt == SL_DWR) && cyc_last) begin
                addr_q  <= dat_addr;
                wide_q  <= dat_wide;
                wdata_q <= dat_wdata;
            end
        end
    end

    // returned data
    always_ff @(posedge clk) begin
        if (rst) begin
            code_valid <= 1'b0;
            rd_valid   <= 1'b0;
            code_data  <= '0;
            rd_data    <= '0;
        end else begin
            code_valid <= (cur == SL_CODE) && slot_last;
            rd_valid   <= (cur == SL_DRD) && (pos == STB_LAST);
            if ((cur == SL_CODE) && slot_last) code_data <= p0_in;
            if ((cur == SL_DRD) && (pos == STB_LAST)) rd_data <= p0_in;
        end
    end

    // pin outputs
    always_comb begin
        ale       = 1'b0;
        psen_n    = 1'b1;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        p0_out    = '0;
        p0_oe     = 1'b0;
        p2_out    = p2_latch;
        p2_strong = 1'b0;
        in_strobe = (pos >= ADDR_END) && (pos <= STB_LAST);
        unique case (cur)
            SL_IDLE: begin
                ale = (slot_pos < ADDR_END);
            end
            SL_CODE: begin
                ale       = (slot_pos < ADDR_END);
                psen_n    = (slot_pos < ADDR_END);
                p0_oe     = (slot_pos < ADDR_END);
                p0_out    = p0_oe ? addr_q[DW-1:0] : '0;
                p2_out    = addr_q[AW-1 -: DW];
                p2_strong = 1'b1;
            end
            SL_DRD, SL_DWR: begin
                ale  = (pos < ADDR_END);
                rd_n = !((cur == SL_DRD) && in_strobe);
                wr_n = !((cur == SL_DWR) && in_strobe);
                if (pos < ADDR_END) begin
                    p0_oe  = 1'b1;
                    p0_out = addr_q[DW-1:0];
                end else if (cur == SL_DWR) begin
                    p0_oe  = 1'b1;
                    p0_out = wdata_q;
                end
                if (wide_q) begin
                    p2_out    = addr_q[AW-1 -: DW];
                    p2_strong = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ale,
    input logic          psen_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic [DW-1:0] p0_out,
    input logic          p0_oe,
    input logic          code_valid,
    input logic          rd_valid
);
    AST_ALE_OFF_DURING_PSEN: assert property (@(posedge clk) disable iff (rst) ale |-> psen_n); // R2
    AST_SINGLE_DATA_STROBE: assert property (@(posedge clk) disable iff (rst) !rd_n |-> wr_n); // R5
    AST_DATA_CYCLE_QUIET: assert property (@(posedge clk) disable iff (rst) (!rd_n || !wr_n) |-> (psen_n && !ale)); // R4
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst) (!wr_n && $past(!wr_n)) |-> ($stable(p0_out) && p0_oe)); // R6
    AST_READ_FLOATS: assert property (@(posedge clk) disable iff (rst) !rd_n |-> !p0_oe); // R7
    AST_CODE_AT_PSEN_END: assert property (@(posedge clk) disable iff (rst) code_valid |-> $rose(psen_n)); // R3
    AST_READ_AT_RD_END: assert property (@(posedge clk) disable iff (rst) rd_valid |-> $rose(rd_n)); // R7
endmodule

bind xbus_seq xbus_seq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_out(p0_out), .p0_oe(p0_oe), .code_valid(code_valid), .rd_valid(rd_valid)
);

// File: tb/sim_xbus_seq.sv
module sim_xbus_seq;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = 16'h1234;
    logic        dat_req = 1'b0, dat_we = 1'b0, dat_wide = 1'b0;
    logic [15:0] dat_addr = 16'h0;
    logic [7:0]  dat_wdata = 8'h0, p2_latch = 8'hC3, p0_in = 8'h00;
    logic        ea_pin = 1'b0, lock1 = 1'b0;
    logic        ale, psen_n, rd_n, wr_n, p0_oe, p2_strong, code_valid, rd_valid;
    logic [7:0]  p0_out, p2_out, code_data, rd_data;

    int checks = 0, errors = 0;
    bit cmp_on = 1'b0;
    int psen_lows = 0;

    xbus_seq u0 (.*);

    always #(CLK_PER/2) clk = ~clk;

    // behavioural reference: kind 0 idle, 1 code, 2 read, 3 write
    int m_pos = 0, m_kind = 0;
    logic [15:0] m_addr = 0;
    logic [7:0]  m_wd = 0, m_cd = 0, m_rd = 0;
    logic m_wide = 0, m_ea = 0, m_cv = 0, m_rv = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_pos = 0; m_kind = 0; m_ea = ea_pin; m_cv = 0; m_rv = 0;
        end else begin
            m_cv = (m_kind == 1) && (m_pos % 6 == 5);
            if (m_cv) m_cd = p0_in;
            m_rv = (m_kind == 2) && (m_pos == 9);
            if (m_rv) m_rd = p0_in;
            if (m_pos % 6 == 5) begin
                if (m_pos == 11 && dat_req) begin
                    m_kind = dat_we ? 3 : 2;
                    m_addr = dat_addr; m_wide = dat_wide; m_wd = dat_wdata;
                end else if (m_kind >= 2 && m_pos == 5) begin
                    m_kind = m_kind;
                end else if (fetch_req && !(lock1 ? m_ea : ea_pin)) begin
                    m_kind = 1; m_addr = fetch_addr; m_wide = 1;
                end else m_kind = 0;
            end
            m_pos = (m_pos + 1) % 12;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!psen_n) psen_lows++;
        if (cmp_on && !rst) begin
            int sp;
            logic e_oe, e_strong;
            sp = m_pos % 6;
            chk(m_kind >= 2 ? "R4 ale" : "R1 ale", ale, (m_kind >= 2) ? (m_pos < 2) : (sp < 2));
            chk(m_kind == 1 ? "R2 psen" : "R4 psen", psen_n, !(m_kind == 1 && sp >= 2));
            chk("R5 rd_n", rd_n, !(m_kind == 2 && m_pos >= 2 && m_pos <= 9));
            chk("R5 wr_n", wr_n, !(m_kind == 3 && m_pos >= 2 && m_pos <= 9));
            e_oe = (m_kind == 1 && sp < 2) || (m_kind >= 2 && m_pos < 2) || (m_kind == 3);
            chk(m_kind == 2 ? "R7 p0_oe" : "R6 p0_oe", p0_oe, e_oe);
            if (e_oe)
                chk(m_kind == 3 ? "R6 p0_out" : "R2 p0_out", p0_out,
                    ((m_kind == 1) || m_pos < 2) ? m_addr[7:0] : m_wd);
            e_strong = (m_kind == 1) || (m_kind >= 2 && m_wide);
            chk("R8 p2_strong", p2_strong, e_strong);
            chk("R8 p2_out", p2_out, e_strong ? m_addr[15:8] : p2_latch);
            chk("R3 code_valid", code_valid, m_cv);
            if (m_cv) chk("R3 code_data", code_data, m_cd);
            chk("R7 rd_valid", rd_valid, m_rv);
            if (m_rv) chk("R7 rd_data", rd_data, m_rd);
        end
    end

    // changing pin and address values so sampling time matters
    always begin
        @(posedge clk); #1;
        p0_in = p0_in + 8'd29;
        fetch_addr = fetch_addr + 16'h0517;
    end

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic ea, input logic lk);
        rst = 1'b1; ea_pin = ea; lock1 = lk;
        clocks(3);
        rst = 1'b0;
    endtask

    task automatic data_op(input logic we, input logic wide, input logic [15:0] a, input logic [7:0] d);
        dat_req = 1'b1; dat_we = we; dat_wide = wide; dat_addr = a; dat_wdata = d;
        clocks(12);
        dat_req = 1'b0;
        clocks(14);
    endtask

    initial begin
        #(CLK_PER * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        clocks(2);
        @(negedge clk);
        // R11 reset values
        chk("R11 ale", ale, 1'b1);
        chk("R11 psen_n", psen_n, 1'b1);
        chk("R11 rd_n", rd_n, 1'b1);
        chk("R11 wr_n", wr_n, 1'b1);
        chk("R11 p0_oe", p0_oe, 1'b0);
        chk("R11 valids", {code_valid, rd_valid}, 2'b00);
        @(posedge clk); #1;
        rst = 1'b0;
        cmp_on = 1'b1;
        clocks(24);
        fetch_req = 1'b1;
        clocks(48);
        data_op(1'b0, 1'b1, 16'hA55A, 8'h00);
        data_op(1'b1, 1'b0, 16'h3C96, 8'hE7);
        data_op(1'b1, 1'b1, 16'hBEEF, 8'h42);
        data_op(1'b0, 1'b0, 16'h0F81, 8'h00);
        fetch_req = 1'b0;
        data_op(1'b0, 1'b1, 16'h7712, 8'h00);
        fetch_req = 1'b1;
        // R9: external access high, no fetch strobes
        ea_pin = 1'b1;
        clocks(1);
        psen_lows = 0;
        clocks(36);
        chk("R9 psen_count", 16'(psen_lows), 16'd0);
        ea_pin = 1'b0;
        clocks(24);
        // R10: locked at reset with pin low, later high ignored
        do_reset(1'b0, 1'b1);
        ea_pin = 1'b1;
        psen_lows = 0;
        clocks(36);
        chk("R10 locked_low", 16'(psen_lows > 0), 16'd1);
        // R10: locked high at reset, later low ignored
        do_reset(1'b1, 1'b1);
        ea_pin = 1'b0;
        psen_lows = 0;
        clocks(36);
        chk("R10 locked_high", 16'(psen_lows), 16'd0);
        // R10: unlocked follows the live pin
        lock1 = 1'b0;
        clocks(12);
        psen_lows = 0;
        clocks(24);
        chk("R10 unlocked", 16'(psen_lows > 0), 16'd1);
        cmp_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule